// File: doc/BRIEF.md
# Dual-Phase Serial Audio Transmitter

This block turns parallel audio words into a single serial data line for a codec or a peer device. An external bit clock and an external frame-sync line set the timing. The block looks for edges on both inputs by sampling them with the system clock. A frame holds one or two phases. Each phase has its own word-length code and its own word count, so a stereo frame can go out as two one-word phases, or as one phase of two words.

Words arrive through a one-entry holding register that uses a valid/ready handshake. When a word moves from the holding register into the shifter, the holding register frees up and `wr_ready` rises again, so the producer can refill it while the current word is still shifting out. If a word is due and the holding register is empty, the previous word is sent again and a sticky underrun flag is set.

Software controls the transmitter through static control inputs. These set the bit-clock edge polarity, a data delay of zero or one bit clock, whether a frame sync that arrives mid-frame is ignored, whether the second phase is enabled, and the length and count fields of each phase. Change these inputs only while the transmit-reset input is high.

Top module: `dual_phase_audio_tx`

## Requirements
- R1: The word-length code selects the number of bits per word: 0→8, 1→12, 2→16, 3→20, 4→24, and 5, 6 or 7→32. A word of N bits is taken from `wr_data[N-1:0]` and is sent MSB first. The upper bits of `wr_data` are ignored.
- R2: Phase A sends `wcnt_a`+1 words of length `wlen_a`. When `dual_en` is 1, phase B follows at once with `wcnt_b`+1 words of length `wlen_b`. When `dual_en` is 0, the frame ends after phase A.
- R3: A frame begins at the shift edge where `fsync` is seen high after being low at the previous shift edge. With `data_delay`=0, the first bit is driven at that same edge. With `data_delay`=1, the first bit is driven at the next shift edge.
- R4: The shift edge is the falling edge of `bclk` when `clk_pol`=1 and the rising edge when `clk_pol`=0. `sdout` changes only at a shift edge, or when the transmitter is put into transmit reset.
- R5: At the shift edge after the last bit of a frame, `sdout` goes to 0. It stays 0 until the next frame drives data.
- R6: With `sync_ignore`=0, a frame-sync rise before the frame is complete sets the sticky `sync_err` and restarts the frame. A rise at the edge just after the last bit is a normal frame start and sets no error.
- R7: With `sync_ignore`=1, a frame-sync rise in the middle of a frame has no effect. The bit stream continues unchanged and `sync_err` stays 0.
- R8: `wr_ready` is 1 while the holding register is empty. A word is accepted on a clock edge where both `wr_valid` and `wr_ready` are 1, and `wr_ready` is 0 from the next cycle. `wr_ready` returns to 1 the cycle after the word moves into the shifter.
- R9: If the holding register is empty when a word is due, the previously loaded word is sent again and `underrun` is set and stays set.
- R10: While `tx_rst` is 1, `sdout` is 0, the framer is idle, and `sync_err` and `underrun` are cleared. The holding register keeps its content and still accepts writes, so it can be primed before the transmitter is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_rst | input | 1 | Holds the transmitter in reset when high |
| clk_pol | input | 1 | 1: shift on falling `bclk`, 0: shift on rising `bclk` |
| data_delay | input | 1 | Bit clocks from frame sync to first bit (0 or 1) |
| sync_ignore | input | 1 | Ignore frame syncs that arrive mid-frame |
| dual_en | input | 1 | Enable the second phase |
| wlen_a | input | 3 | Word-length code, phase A |
| wcnt_a | input | CNT_W | Words in phase A minus one |
| wlen_b | input | 3 | Word-length code, phase B |
| wcnt_b | input | CNT_W | Words in phase B minus one |
| bclk | input | 1 | Bit clock, sampled by `clk` |
| fsync | input | 1 | Frame sync, active high, sampled at shift edges |
| wr_data | input | 32 | Word to send, right-justified |
| wr_valid | input | 1 | `wr_data` is valid |
| wr_ready | output | 1 | Holding register is empty |
| sdout | output | 1 | Serial data out |
| sync_err | output | 1 | Sticky: frame sync arrived before the frame was complete |
| underrun | output | 1 | Sticky: a word was repeated because the holding register was empty |

## Verification
The end of a frame and the start of the next can fall on the same shift edge. With zero data delay and back-to-back frames, the last-bit edge of one frame and the frame-sync edge of the next coincide. The bench provokes this by raising `fsync` exactly at the edge after the final bit. It then checks that the first bit of the new frame appears at that edge with no gap and that `sync_err` stays 0. A mid-frame sync is the contrasting case: it must raise the error flag, or, when ignoring is enabled, leave the stream untouched.

// File: rtl/dpa_tx_pkg.sv
package dpa_tx_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_DELAY, ST_SHIFT} tx_state_e;

  // length code to bit count; spare codes give the widest word
  function automatic logic [5:0] wlen_bits(input logic [2:0] code);
    case (code)
      3'd0:    wlen_bits = 6'd8;
      3'd1:    wlen_bits = 6'd12;
      3'd2:    wlen_bits = 6'd16;
      3'd3:    wlen_bits = 6'd20;
      3'd4:    wlen_bits = 6'd24;
      default: wlen_bits = 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/dpa_tx_edge.sv
module dpa_tx_edge (
  input  logic clk,
  input  logic rst,
  input  logic tx_rst,
  input  logic clk_pol,
  input  logic bclk,
  input  logic fsync,
  output logic shift_en,
  output logic fs_rise
);
  logic bclk_q;
  logic fs_prev;

  always_ff @(posedge clk) begin
    if (rst) bclk_q <= 1'b0;
    else     bclk_q <= bclk;
  end

  // shift edge: falling bclk for clk_pol=1, rising for clk_pol=0
  assign shift_en = clk_pol ? (bclk_q & ~bclk) : (~bclk_q & bclk);

  always_ff @(posedge clk) begin
    if (rst || tx_rst)  fs_prev <= 1'b0;
    else if (shift_en)  fs_prev <= fsync;
  end

  assign fs_rise = shift_en & fsync & ~fs_prev;
endmodule

// File: rtl/dpa_tx_hold.sv
module dpa_tx_hold #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_rst,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_valid,
  input  logic          take,
  output logic          wr_ready,
  output logic [DW-1:0] word,
  output logic          underrun
);
  logic          full;
  logic [DW-1:0] buf_q;
  logic [DW-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full   <= 1'b0;
      buf_q  <= '0;
      last_q <= '0;
    end else if (take && full) begin
      full   <= 1'b0;
      last_q <= buf_q;
    end else if (wr_valid && !full) begin
      full   <= 1'b1;
      buf_q  <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || tx_rst)      underrun <= 1'b0;
    else if (take && !full) underrun <= 1'b1;
  end

  assign wr_ready = ~full;
  assign word     = full ? buf_q : last_q;

  assert_accept_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |=> !wr_ready);
  assert_release_R8: assert property (@(posedge clk) disable iff (rst)
    (take && !wr_ready) |=> wr_ready);
  assert_underrun_R9: assert property (@(posedge clk) disable iff (rst)
    (take && wr_ready && !tx_rst) |=> underrun);
endmodule

// File: rtl/dpa_tx_framer.sv
module dpa_tx_framer
  import dpa_tx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_rst,
  input  logic              shift_en,
  input  logic              fs_rise,
  input  logic              data_delay,
  input  logic              sync_ignore,
  input  logic              dual_en,
  input  logic [2:0]        wlen_a,
  input  logic [CNT_W-1:0]  wcnt_a,
  input  logic [2:0]        wlen_b,
  input  logic [CNT_W-1:0]  wcnt_b,
  input  logic [WORD_W-1:0] word,
  output logic              take,
  output logic              sdout,
  output logic              sync_err
);
  localparam int BC_W = $clog2(WORD_W);

  tx_state_e         st, nst;
  logic              phase, nphase;
  logic [CNT_W-1:0]  wcnt, nwcnt;
  logic [BC_W-1:0]   bcnt, nbcnt;
  logic [WORD_W-1:0] shreg, nshreg;
  logic              nsd;
  logic              load;
  logic [2:0]        lcode;
  logic [5:0]        nbits;
  logic [WORD_W-1:0] aligned;
  logic              last_word, at_end, mid, restart;

  assign last_word = (wcnt == '0) && (phase || !dual_en);
  assign at_end    = (st == ST_SHIFT) && (bcnt == '0) && last_word;
  assign mid       = (st == ST_DELAY) || ((st == ST_SHIFT) && !at_end);
  assign restart   = shift_en && fs_rise && !(mid && sync_ignore);

  always_comb begin
    nst    = st;
    nphase = phase;
    nwcnt  = wcnt;
    nbcnt  = bcnt;
    nshreg = shreg;
    nsd    = sdout;
    load   = 1'b0;
    lcode  = wlen_a;
    if (restart) begin
      nphase = 1'b0;
      nwcnt  = wcnt_a;
      if (data_delay) begin
        nst = ST_DELAY;
        nsd = 1'b0;
      end else begin
        nst  = ST_SHIFT;
        load = 1'b1;
      end
    end else if (shift_en) begin
      case (st)
        ST_DELAY: begin
          nst  = ST_SHIFT;
          load = 1'b1;
        end
        ST_SHIFT: begin
          if (bcnt != '0) begin
            nsd    = shreg[WORD_W-1];
            nshreg = shreg << 1;
            nbcnt  = bcnt - BC_W'(1);
          end else if (wcnt != '0) begin
            nwcnt = wcnt - CNT_W'(1);
            load  = 1'b1;
            lcode = phase ? wlen_b : wlen_a;
          end else if (!phase && dual_en) begin
            nphase = 1'b1;
            nwcnt  = wcnt_b;
            load   = 1'b1;
            lcode  = wlen_b;
          end else begin
            nst = ST_IDLE;
            nsd = 1'b0;
          end
        end
        default: nsd = 1'b0;
      endcase
    end
    nbits   = wlen_bits(lcode);
    aligned = word << (6'd32 - nbits);
    if (load) begin
      nsd    = aligned[WORD_W-1];
      nshreg = aligned << 1;
      nbcnt  = BC_W'(nbits - 6'd1);
    end
  end

  assign take = load && !tx_rst;

  always_ff @(posedge clk) begin
    if (rst || tx_rst) begin
      st    <= ST_IDLE;
      phase <= 1'b0;
      wcnt  <= '0;
      bcnt  <= '0;
      shreg <= '0;
      sdout <= 1'b0;
    end else begin
      st    <= nst;
      phase <= nphase;
      wcnt  <= nwcnt;
      bcnt  <= nbcnt;
      shreg <= nshreg;
      sdout <= nsd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || tx_rst)       sync_err <= 1'b0;
    else if (restart && mid) sync_err <= 1'b1;
  end

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !sdout);
  assert_edge_only_R4: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !tx_rst) |=> $stable(sdout));
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (sync_err && !tx_rst) |=> sync_err);
  assert_ignore_R7: assert property (@(posedge clk) disable iff (rst)
    (shift_en && fs_rise && mid && sync_ignore && !tx_rst) |=> $stable(sync_err));
  assert_txrst_R10: assert property (@(posedge clk) disable iff (rst)
    tx_rst |=> (!sync_err && !sdout && st == ST_IDLE));
endmodule

// File: rtl/dual_phase_audio_tx.sv
module dual_phase_audio_tx
  import dpa_tx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_rst,
  input  logic              clk_pol,
  input  logic              data_delay,
  input  logic              sync_ignore,
  input  logic              dual_en,
  input  logic [2:0]        wlen_a,
  input  logic [CNT_W-1:0]  wcnt_a,
  input  logic [2:0]        wlen_b,
  input  logic [CNT_W-1:0]  wcnt_b,
  input  logic              bclk,
  input  logic              fsync,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic              sdout,
  output logic              sync_err,
  output logic              underrun
);
  logic              shift_en, fs_rise, take;
  logic [WORD_W-1:0] word;

  dpa_tx_edge u_edge (
    .clk(clk), .rst(rst), .tx_rst(tx_rst), .clk_pol(clk_pol),
    .bclk(bclk), .fsync(fsync), .shift_en(shift_en), .fs_rise(fs_rise)
  );

  dpa_tx_hold #(.DW(WORD_W)) u_hold (
    .clk(clk), .rst(rst), .tx_rst(tx_rst), .wr_data(wr_data),
    .wr_valid(wr_valid), .take(take), .wr_ready(wr_ready),
    .word(word), .underrun(underrun)
  );

  dpa_tx_framer #(.CNT_W(CNT_W)) u_framer (
    .clk(clk), .rst(rst), .tx_rst(tx_rst), .shift_en(shift_en),
    .fs_rise(fs_rise), .data_delay(data_delay), .sync_ignore(sync_ignore),
    .dual_en(dual_en), .wlen_a(wlen_a), .wcnt_a(wcnt_a), .wlen_b(wlen_b),
    .wcnt_b(wcnt_b), .word(word), .take(take), .sdout(sdout),
    .sync_err(sync_err)
  );
endmodule

// File: tb/dual_phase_audio_tx_test.sv
module dual_phase_audio_tx_test;
  localparam int CW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, tx_rst, clk_pol, data_delay, sync_ignore, dual_en;
  logic [2:0] wlen_a, wlen_b;
  logic [CW-1:0] wcnt_a, wcnt_b;
  logic bclk, fsync;
  logic [31:0] wr_data;
  logic wr_valid, wr_ready, sdout, sync_err, underrun;

  dual_phase_audio_tx #(.CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .tx_rst(tx_rst), .clk_pol(clk_pol),
    .data_delay(data_delay), .sync_ignore(sync_ignore), .dual_en(dual_en),
    .wlen_a(wlen_a), .wcnt_a(wcnt_a), .wlen_b(wlen_b), .wcnt_b(wcnt_b),
    .bclk(bclk), .fsync(fsync), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .sdout(sdout), .sync_err(sync_err),
    .underrun(underrun)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  int stab_bad;
  logic [31:0] feed_q[$];
  bit eb[$];
  bit fsl[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // feeder: pushes queued words whenever the holding register is free
  always @(negedge clk) begin
    if (!rst && wr_ready && !wr_valid && feed_q.size() > 0) begin
      wr_data  <= feed_q.pop_front();
      wr_valid <= 1'b1;
    end else begin
      wr_valid <= 1'b0;
    end
  end

  function automatic int wbits(input logic [2:0] c);
    case (c)
      3'd0: return 8;
      3'd1: return 12;
      3'd2: return 16;
      3'd3: return 20;
      3'd4: return 24;
      default: return 32;
    endcase
  endfunction

  task automatic add_word(input logic [31:0] w, input logic [2:0] c, input bit feed);
    if (feed) feed_q.push_back(w);
    for (int b = wbits(c) - 1; b >= 0; b--) begin
      eb.push_back(w[b]);
      fsl.push_back(1'b0);
    end
  endtask

  task automatic frame(input bit dly, input bit dual, input logic [2:0] ca,
                       input int na, input logic [2:0] cb, input int nb,
                       output int s);
    s = eb.size();
    if (dly) begin eb.push_back(1'b0); fsl.push_back(1'b0); end
    for (int i = 0; i <= na; i++) add_word($urandom, ca, 1'b1);
    if (dual) for (int i = 0; i <= nb; i++) add_word($urandom, cb, 1'b1);
    fsl[s] = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin eb.push_back(1'b0); fsl.push_back(1'b0); end
  endtask

  task automatic cfg(input bit pol, input bit dly, input bit ign, input bit dual,
                     input logic [2:0] ca, input int na, input logic [2:0] cb, input int nb);
    @(negedge clk);
    tx_rst = 1'b1;
    clk_pol = pol; data_delay = dly; sync_ignore = ign; dual_en = dual;
    wlen_a = ca; wcnt_a = CW'(na); wlen_b = cb; wcnt_b = CW'(nb);
    bclk = pol; fsync = 1'b0;
    eb.delete(); fsl.delete();
  endtask

  task automatic go();
    repeat (4) @(negedge clk);
    tx_rst = 1'b0;
  endtask

  // one bit-clock period: shift edge, sample, opposite edge, stability check
  task automatic tick(input bit fs, output logic got);
    @(negedge clk);
    bclk = ~clk_pol;
    fsync = fs;
    repeat (2) @(negedge clk);
    got = sdout;
    bclk = clk_pol;
    repeat (2) @(negedge clk);
    if (sdout !== got) stab_bad++;
  endtask

  task automatic play(input string req, input string tag);
    int bad = 0;
    int first = -1;
    logic got;
    logic fgot;
    stab_bad = 0;
    fgot = 1'b0;
    for (int i = 0; i < eb.size(); i++) begin
      tick(fsl[i], got);
      if (got !== eb[i]) begin
        if (first < 0) begin first = i; fgot = got; end
        bad++;
      end
    end
    if (first >= 0)
      $display("  %s first mismatch at bit %0d: got %0b expected %0b", tag, first, fgot, eb[first]);
    check(bad == 0, req, {tag, " bit mismatches"}, bad, 0);
    check(stab_bad == 0, "R4", {tag, " sdout moved off shift edge"}, stab_bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
      $finish;
    end
  end

  initial begin
    int s, s2;
    logic got;
    logic [31:0] w;
    void'($urandom(32'd4242));
    rst = 1'b1; tx_rst = 1'b1; clk_pol = 1'b1; data_delay = 1'b0;
    sync_ignore = 1'b0; dual_en = 1'b0; wlen_a = 3'd2; wlen_b = 3'd2;
    wcnt_a = '0; wcnt_b = '0; bclk = 1'b1; fsync = 1'b0;
    wr_data = '0; wr_valid = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check(sdout == 1'b0, "R10", "reset sdout", sdout, 0);
    check(sync_err == 1'b0, "R10", "reset sync_err", sync_err, 0);
    check(underrun == 1'b0, "R10", "reset underrun", underrun, 0);
    check(wr_ready == 1'b1, "R8", "reset wr_ready", wr_ready, 1);

    // A: falling-edge shift, delay 1, one phase of two 16-bit words
    cfg(1, 1, 0, 0, 3'd2, 1, 3'd0, 0);
    frame(1, 0, 3'd2, 1, 3'd0, 0, s);
    idle(3);
    repeat (4) @(negedge clk);
    check(wr_ready == 1'b0, "R8", "primed holding register wr_ready", wr_ready, 0);
    go();
    play("R3", "A delay1 2x16");
    check(wr_ready == 1'b1, "R8", "holding drained wr_ready", wr_ready, 1);
    check(sync_err == 1'b0, "R5", "A sync_err", sync_err, 0);

    // B: rising-edge shift, delay 0, two phases 1x8 then 2x32
    cfg(0, 0, 0, 1, 3'd0, 0, 3'd5, 1);
    frame(0, 1, 3'd0, 0, 3'd5, 1, s);
    idle(3);
    go();
    play("R2", "B dual 8/32");

    // C: random configurations, including spare length codes
    for (int k = 0; k < 6; k++) begin
      bit p, d, du;
      logic [2:0] ca, cb;
      int na, nb;
      p = 1'($urandom); d = 1'($urandom); du = 1'($urandom);
      ca = 3'($urandom); cb = 3'($urandom);
      na = int'($urandom % 3); nb = int'($urandom % 3);
      cfg(p, d, 0, du, ca, na, cb, nb);
      frame(d, du, ca, na, cb, nb, s);
      idle(2);
      go();
      play("R1", $sformatf("C random %0d", k));
      check(underrun == 1'b0, "R9", "C no underrun when fed", underrun, 0);
    end

    // D: back-to-back frames, delay 0, sync on the edge after the last bit
    cfg(1, 0, 0, 0, 3'd1, 1, 3'd0, 0);
    frame(0, 0, 3'd1, 1, 3'd0, 0, s);
    frame(0, 0, 3'd1, 1, 3'd0, 0, s2);
    idle(2);
    go();
    play("R6", "D back-to-back");
    check(sync_err == 1'b0, "R6", "D sync at frame end is no error", sync_err, 0);

    // F: mid-frame sync ignored
    cfg(0, 1, 1, 0, 3'd3, 1, 3'd0, 0);
    frame(1, 0, 3'd3, 1, 3'd0, 0, s);
    fsl[s + 9] = 1'b1;
    idle(2);
    go();
    play("R7", "F mid sync ignored");
    check(sync_err == 1'b0, "R7", "F sync_err", sync_err, 0);

    // E: underrun, second word repeats the first
    cfg(1, 0, 0, 0, 3'd2, 1, 3'd0, 0);
    s = eb.size();
    w = $urandom;
    add_word(w, 3'd2, 1'b1);
    add_word(w, 3'd2, 1'b0);
    fsl[s] = 1'b1;
    idle(2);
    go();
    play("R9", "E repeated word");
    check(underrun == 1'b1, "R9", "E underrun flag", underrun, 1);
    @(negedge clk) tx_rst = 1'b1;
    repeat (3) @(negedge clk);
    check(underrun == 1'b0, "R10", "E underrun cleared by tx_rst", underrun, 0);

    // G: mid-frame sync not ignored, delay 1
    cfg(1, 1, 0, 0, 3'd2, 1, 3'd0, 0);
    frame(1, 0, 3'd2, 1, 3'd0, 0, s);
    go();
    tick(1'b1, got);
    check(got == 1'b0, "R3", "G delay slot", got, 0);
    for (int i = 0; i < 5; i++) tick(1'b0, got);
    check(sync_err == 1'b0, "R6", "G no error before mid sync", sync_err, 0);
    tick(1'b1, got);
    check(sync_err == 1'b1, "R6", "G mid sync sets sync_err", sync_err, 1);
    check(got == 1'b0, "R6", "G restart enters delay slot", got, 0);
    @(negedge clk) tx_rst = 1'b1;
    repeat (3) @(negedge clk);
    check(sync_err == 1'b0, "R10", "G sync_err cleared by tx_rst", sync_err, 0);
    check(sdout == 1'b0, "R10", "G sdout in tx_rst", sdout, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule